// File: doc/BRIEF.md
# Dual Down-Counting Timer with Free-Run and Auto-Reload Modes

The block contains two independent 16-bit down-counters. Each one advances on a shared timer-reference strobe (`ref_tick`). A per-timer clock-select bit chooses between two rates. The counter can step on every strobe, or only on every 256th strobe, counted by a private 8-bit prescaler. A per-timer mode bit chooses what happens when the counter steps down from zero. In free-running mode the counter wraps to 0xFFFF and keeps counting. In auto-reload mode it is refilled with the last value written to that timer's load register.

Software uses a single write port and a single read port. Each timer's load register and one shared control word are selected by address. A read returns the live count of a timer, or the control word, and has no effect on counting. Every underflow raises a one-cycle interrupt pulse on that timer's bit of `irq`. The interrupt controller and the bus protocol sit outside the block.

Top module: `dual_dntimer`

## Requirements
- R1: After reset both counters, both reload values, both prescalers and the control word are zero, and `irq` is low.
- R2: In free-running mode (mode bit 0), a step taken while the count is 0 sets the count to 0xFFFF, and later steps continue counting down from there.
- R3: In auto-reload mode (mode bit 1), a step taken while the count is 0 sets the count to the value most recently written to that timer's load register.
- R4: A counter changes only on a step or a load write. Cycles without either, and any read, leave it unchanged.
- R5: Every underflow, in either mode, drives that timer's `irq` bit high for exactly the one cycle after the stepping edge. A step from a non-zero count leaves `irq` low.
- R6: With clock select 1, the timer steps on every `ref_tick`. With clock select 0, it steps only on the strobe that finds its prescaler at 255, which is every 256th strobe.
- R7: A write to address 0 (timer 0) or address 1 (timer 1) sets that counter and its reload value to `wr_data`. The new value can be read on the next cycle.
- R8: A control write that changes a timer's clock-select bit clears that timer's prescaler, so the next divided step comes 256 strobes later.
- R9: If a load write and an underflow step hit the same timer in the same cycle, the write wins. The count takes the written value and no interrupt is raised.
- R10: The control word sits at address 2 and uses these bits: bit 4 is timer 0 mode, bit 5 is timer 0 select, bit 6 is timer 1 mode, and bit 7 is timer 1 select. All other bits read back as 0. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Timer-reference strobe, one cycle per reference period |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write address: 0 timer 0 load, 1 timer 1 load, 2 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 16 | Read data (combinational): live count or control word |
| irq | output | 2 | Per-timer underflow pulse, one cycle |

## Verification
The bound assertions check, on every cycle, the per-step rules of each timer:
- after a free-running underflow the count is 0xFFFF;
- after an auto-reload underflow the count equals the stored reload value;
- an interrupt comes only from a step taken at zero;
- the count holds when there is neither a step nor a load;
- a divided step happens only at prescaler 255;
- a load write suppresses the interrupt.

Other behaviours need the bench's cycle-accurate reference model and longer scenarios:
- the true 256-strobe spacing;
- the prescaler clear on a select change;
- continued counting after a wrap;
- the control-word readback mask.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;

  // Bit position of timer n's mode bit inside the control word.
  function automatic int mode_bit(input int n);
    return 4 + 2 * n;
  endfunction

  // Bit position of timer n's clock-select bit inside the control word.
  function automatic int sel_bit(input int n);
    return 5 + 2 * n;
  endfunction

  // Mask of all defined control bits for a given timer count.
  function automatic logic [31:0] ctrl_mask(input int n_tmr);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < n_tmr; k++) begin
      m[mode_bit(k)] = 1'b1;
      m[sel_bit(k)]  = 1'b1;
    end
    return m;
  endfunction

  // Count value that follows one step.
  function automatic logic [31:0] step_value(input logic [31:0] cur,
                                             input logic [31:0] rld,
                                             input logic        reload_mode,
                                             input int          width);
    logic [31:0] all_ones;
    all_ones = (32'h1 << width) - 32'h1;
    if (cur == 32'h0) return reload_mode ? rld : all_ones;
    return cur - 32'h1;
  endfunction

endpackage

// File: rtl/dntimer_prescale.sv
module dntimer_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sel_direct_i,
  input  logic             clr_i,
  output logic [PRE_W-1:0] pre_o,
  output logic             adv_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        pre_q <= '0;
    else if (clr_i)                    pre_q <= '0;
    else if (tick_i && !sel_direct_i)  pre_q <= pre_q + 1'b1;
  end

  assign pre_o = pre_q;
  assign adv_o = tick_i && (sel_direct_i || (pre_q == '1));
endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
  import dntimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             adv_i,
  input  logic             reload_mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q, stepped;
  logic             irq_q, uflow;

  assign uflow   = adv_i && !load_we_i && (cnt_q == '0);
  assign stepped = CNT_W'(step_value(32'(cnt_q), 32'(rld_q), reload_mode_i, CNT_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= uflow;
      if (load_we_i) begin
        cnt_q <= load_data_i;
        rld_q <= load_data_i;
      end else if (adv_i) begin
        cnt_q <= stepped;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
  import dntimer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ref_tick,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_TMR+1)-1:0]    wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  input  logic [$clog2(NUM_TMR+1)-1:0]    rd_addr,
  output logic [CNT_W-1:0]                rd_data,
  output logic [NUM_TMR-1:0]              irq
);
  localparam int              ADDR_W    = $clog2(NUM_TMR + 1);
  localparam logic [CNT_W-1:0] CTRL_MASK = CNT_W'(ctrl_mask(NUM_TMR));

  logic [CNT_W-1:0]               ctrl_q;
  logic                           ctrl_we;
  logic [NUM_TMR-1:0]             ld_we, sel_chg, adv_v;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_v, rld_v;
  logic [NUM_TMR-1:0][PRE_W-1:0]  pre_v;

  assign ctrl_we = wr_en && (wr_addr == ADDR_W'(NUM_TMR));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data & CTRL_MASK;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int MB = mode_bit(i);
    localparam int SB = sel_bit(i);

    assign ld_we[i]   = wr_en && (wr_addr == ADDR_W'(i));
    assign sel_chg[i] = ctrl_we && (wr_data[SB] != ctrl_q[SB]);

    dntimer_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (ref_tick),
      .sel_direct_i (ctrl_q[SB]),
      .clr_i        (sel_chg[i]),
      .pre_o        (pre_v[i]),
      .adv_o        (adv_v[i])
    );

    dntimer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_we_i     (ld_we[i]),
      .load_data_i   (wr_data),
      .adv_i         (adv_v[i]),
      .reload_mode_i (ctrl_q[MB]),
      .cnt_o         (cnt_v[i]),
      .rld_o         (rld_v[i]),
      .irq_o         (irq[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_TMR; k++)
      if (rd_addr == ADDR_W'(k)) rd_data = cnt_v[k];
    if (rd_addr == ADDR_W'(NUM_TMR)) rd_data = ctrl_q;
  end
endmodule

// File: rtl/dntimer_check.sv
module dntimer_check
  import dntimer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ref_tick,
  input logic [NUM_TMR-1:0]             ld_we,
  input logic [NUM_TMR-1:0]             adv_v,
  input logic [NUM_TMR-1:0]             irq,
  input logic [CNT_W-1:0]               ctrl_q,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_v,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  rld_v,
  input logic [NUM_TMR-1:0][PRE_W-1:0]  pre_v
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    localparam int MB = mode_bit(i);
    localparam int SB = sel_bit(i);

    a_r2_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !$past(ctrl_q[MB])) |-> (cnt_v[i] == '1));

    a_r3_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && $past(ctrl_q[MB])) |-> (cnt_v[i] == rld_v[i]));

    a_r5_irq_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ($past(cnt_v[i]) == '0 && $past(adv_v[i])));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(adv_v[i]) && !$past(ld_we[i])) |-> $stable(cnt_v[i]));

    a_r6_divided_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv_v[i] |-> (ref_tick && (ctrl_q[SB] || pre_v[i] == '1)));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we[i] |=> !irq[i]);
  end
endmodule

bind dual_dntimer dntimer_check #(
  .NUM_TMR (NUM_TMR),
  .CNT_W   (CNT_W),
  .PRE_W   (PRE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_tick (ref_tick),
  .ld_we    (ld_we),
  .adv_v    (adv_v),
  .irq      (irq),
  .ctrl_q   (ctrl_q),
  .cnt_v    (cnt_v),
  .rld_v    (rld_v),
  .pre_v    (pre_v)
);

// File: tb/dual_dntimer_test.sv
module dual_dntimer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  irq;

  dual_dntimer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  int m_cnt[2];
  int m_rld[2];
  int m_pre[2];
  int m_irq[2];
  int m_ctrl;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(int'(irq[0]), m_irq[0], "R5", "irq0");
    chk(int'(irq[1]), m_irq[1], "R5", "irq1");
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      if (a < 2)       chk(int'(rd_data), m_cnt[a], tag, $sformatf("count%0d", a));
      else if (a == 2) chk(int'(rd_data), m_ctrl, "R10", "control");
      else             chk(int'(rd_data), 0, "R10", "unused address");
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(input bit tk, input bit we, input int addr, input int data, input string tag);
    int new_pre[2];
    ref_tick = tk; wr_en = we; wr_addr = 2'(addr); wr_data = 16'(data);
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      int mb = 4 + 2 * i;
      int sb = 5 + 2 * i;
      bit sel  = ((m_ctrl >> sb) & 1) != 0;
      bit mode = ((m_ctrl >> mb) & 1) != 0;
      bit adv  = tk && (sel || m_pre[i] == 255);
      bit cw   = we && addr == 2;
      new_pre[i] = m_pre[i];
      if (cw && ((((data >> sb) & 1) != 0) != sel)) new_pre[i] = 0;
      else if (tk && !sel) new_pre[i] = (m_pre[i] + 1) % 256;
      m_irq[i] = 0;
      if (we && addr == i) begin
        m_cnt[i] = data & 16'hFFFF;
        m_rld[i] = data & 16'hFFFF;
      end else if (adv) begin
        if (m_cnt[i] == 0) begin
          m_irq[i] = 1;
          m_cnt[i] = mode ? m_rld[i] : 16'hFFFF;
        end else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    m_pre = new_pre;
    if (we && addr == 2) m_ctrl = data & 16'h00F0;
    @(negedge clk);
    ref_tick = 0; wr_en = 0;
    compare_all(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, 0, 0, 0, tag);
  endtask

  task automatic idles(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int addr, input int data, input string tag);
    step(0, 1, addr, data, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0; m_pre[i] = 0; m_irq[i] = 0;
    end
    m_ctrl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    compare_all("R1");

    // R7 load and R10 layout, both timers direct, free running
    wr(2, 16'h00A0, "R10");
    wr(0, 5, "R7");
    wr(1, 3, "R7");
    // R2: timer 0 wraps to FFFF and keeps counting; timer 1 too
    ticks(10, "R2");

    // R3: timer 1 auto-reload, direct select
    wr(2, 16'h00E0, "R10");
    wr(1, 2, "R7");
    ticks(9, "R3");

    // R4: no steps and repeated reads leave counts alone
    idles(5, "R4");

    // R3 with reload of zero: underflow on every strobe
    wr(1, 0, "R3");
    ticks(3, "R3");

    // R9: load write in the same cycle as an underflow step
    wr(0, 0, "R9");
    step(1, 1, 0, 7, "R9");
    ticks(2, "R9");

    // R6: both timers divided by 256
    wr(2, 16'h0040, "R6");
    wr(0, 1, "R6");
    wr(1, 1, "R6");
    ticks(600, "R6");

    // R8: select toggled mid-count clears the prescaler
    ticks(100, "R8");
    wr(2, 16'h0060, "R8");
    wr(2, 16'h0040, "R8");
    ticks(300, "R8");

    // R10: undefined control bits read back as zero
    wr(2, 16'hFFFF, "R10");
    ticks(4, "R10");
    idles(2, "R4");

    report();
  end
endmodule